// File: doc/BRIEF.md
# Microcode Store Access Port

This block gives running microcode read and write access to a writable control store. The store has 1024 words of 32 bits, and software moves data to and from it in 16-bit halves. A write is spread over two consecutive microinstructions. The strobe cycle supplies the address. In the cycle after it, the holding register supplies the upper half and the ALU result supplies the lower half, and the whole word is committed together.

A read selects one half of the addressed word. That half is returned as an AND mask on the processor bus. When no read data is being presented, the mask is all ones, so it leaves the other bus sources unchanged.

Every accepted access asks the clock-stop controller for exactly one stalled cycle. Strobes that arrive during that stalled cycle are ignored, because the microinstruction is frozen. If another stall cause is active when an access is accepted, a sticky flag marks the outcome as unspecified. The two stall causes are not merged in any way.

Top module: `ucs_port`

## Requirements
- R1: After an accepted write strobe, the value on `hold_in` in the following cycle becomes bits 31:16 of the addressed word.
- R2: The value on `alu_in` in that same following cycle becomes bits 15:0 of the same word. The address is captured at the strobe and held for the second cycle.
- R3: Each accepted read or write strobe drives `stall_o` high for exactly the next cycle and no other.
- R4: A read returns bits 31:16 when `bus_in[10]` is 1 and bits 15:0 when it is 0. The data appears on `bus_and_o` in the cycle after the strobe.
- R5: In every cycle that does not present read data, `bus_and_o` is all ones (neutral for the AND on the bus).
- R6: The store address is `bus_in[9:0]`, so addresses wrap modulo 1024 and bits 15:11 have no effect.
- R7: Strobes that arrive while `stall_o` is high are ignored: they cause no stall, no read data and no write.
- R8: When read and write strobes arrive together, only the write is performed and no read data is presented. On writes, `bus_in[10]` is ignored.
- R9: If `other_stall` is high when an access is accepted, `unspec_o` is set and stays set until reset. The stall timing is unchanged.
- R10: During and right after reset, `stall_o` is 0, `unspec_o` is 0 and `bus_and_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Decoded read strobe |
| wr_stb | input | 1 | Decoded write strobe |
| bus_in | input | 16 | Processor bus: address in bits 9:0, half select in bit 10 |
| hold_in | input | 16 | Holding register value (upper half source) |
| alu_in | input | 16 | ALU result (lower half source) |
| other_stall | input | 1 | Another clock-stop cause is active |
| stall_o | output | 1 | One-cycle clock-stop request |
| bus_and_o | output | 16 | AND mask onto the processor bus |
| unspec_o | output | 1 | Sticky flag: an access overlapped another stall |

## Verification
The assertions check the cycle-level rules on every cycle:
- the stall lasts exactly one cycle;
- strobes during a stall are dropped;
- a write wins over a simultaneous read;
- the captured address holds through the second write cycle;
- the flag is sticky;
- the mask is neutral whenever no stall is in progress.

Only the bench's scenarios can show that data lands where it should. They confirm that the two halves of a word come from the right sources in the right cycle, that the half selection and the address wrap-around return the stored values, and that a write which overlapped ignored strobes still completes at the captured address.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ucs_op_e;
endpackage

// File: rtl/ucs_store.sv
module ucs_store #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // single clock, one write and one registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ucs_seq.sv
module ucs_seq
  import ucs_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BUS_W   = 16,
  parameter int SEL_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              other_stall,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_present,
  output logic              sel_hi,
  output logic              stall,
  output logic              unspec
);
  ucs_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              half_q;
  logic              conflict_q;
  logic              accept;
  logic              wr_go;

  assign accept  = (op_q == OP_IDLE);
  assign wr_go   = wr_stb & accept;
  assign rd_go   = rd_stb & accept & ~wr_stb;
  assign rd_addr = bus_in[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q       <= OP_IDLE;
      addr_q     <= '0;
      half_q     <= 1'b0;
      conflict_q <= 1'b0;
    end else begin
      if (wr_go)      op_q <= OP_WRITE;
      else if (rd_go) op_q <= OP_READ;
      else            op_q <= OP_IDLE;
      if (wr_go || rd_go) begin
        addr_q <= bus_in[ADDR_W-1:0];
        half_q <= bus_in[SEL_BIT];
        if (other_stall) conflict_q <= 1'b1;
      end
    end
  end

  assign wr_commit  = (op_q == OP_WRITE);
  assign wr_addr    = addr_q;
  assign rd_present = (op_q == OP_READ);
  assign sel_hi     = half_q;
  assign stall      = (op_q != OP_IDLE);
  assign unspec     = conflict_q;

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R3
  AST_STALL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((rd_stb || wr_stb) && !stall) |=> stall); // R3
  AST_DROP_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!wr_commit && !rd_present)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && wr_stb && !stall) |=> (wr_commit && !rd_present)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(addr_q)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    unspec |=> unspec); // R9
endmodule

// File: rtl/ucs_rdmux.sv
module ucs_rdmux #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] word,
  input  logic                present,
  input  logic                sel_hi,
  output logic [HALF_W-1:0]   mask
);
  logic [HALF_W-1:0] half;

  assign half = sel_hi ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];
  assign mask = present ? half : '1;
endmodule

// File: rtl/ucs_port.sv
module ucs_port #(
  parameter int ADDR_W  = 10,
  parameter int HALF_W  = 16,
  parameter int SEL_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [HALF_W-1:0] bus_in,
  input  logic [HALF_W-1:0] hold_in,
  input  logic [HALF_W-1:0] alu_in,
  input  logic              other_stall,
  output logic              stall_o,
  output logic [HALF_W-1:0] bus_and_o,
  output logic              unspec_o
);
  localparam int WORD_W = 2 * HALF_W;

  logic              rd_go;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_present;
  logic              sel_hi;
  logic [WORD_W-1:0] rword;

  ucs_seq #(.ADDR_W(ADDR_W), .BUS_W(HALF_W), .SEL_BIT(SEL_BIT)) u_seq (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_in(bus_in),
    .other_stall(other_stall), .rd_go(rd_go), .rd_addr(rd_addr),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .rd_present(rd_present),
    .sel_hi(sel_hi), .stall(stall_o), .unspec(unspec_o)
  );

  ucs_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .we(wr_commit), .waddr(wr_addr), .wdata({hold_in, alu_in}),
    .re(rd_go), .raddr(rd_addr), .rdata(rword)
  );

  ucs_rdmux #(.HALF_W(HALF_W)) u_mux (
    .word(rword), .present(rd_present), .sel_hi(sel_hi), .mask(bus_and_o)
  );

  AST_MASK_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    !stall_o |-> (bus_and_o == '1)); // R5
endmodule

// File: tb/ucs_port_test.sv
`timescale 1ns/1ps
module ucs_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0, wr_stb = 1'b0, other_stall = 1'b0;
  logic [15:0] bus_in = '0, hold_in = '0, alu_in = '0;
  logic        stall_o, unspec_o;
  logic [15:0] bus_and_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ucs_port uut (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_in(bus_in),
    .hold_in(hold_in), .alu_in(alu_in), .other_stall(other_stall),
    .stall_o(stall_o), .bus_and_o(bus_and_o), .unspec_o(unspec_o)
  );

  // behavioural reference model
  logic [31:0] mdl [int];
  bit          m_busy, m_wrp, m_rdp, m_flag, m_half;
  int          m_addr;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_wrp = 0; m_rdp = 0; m_flag = 0;
    end else begin
      bit nw, nr;
      if (m_wrp) mdl[m_addr] = {hold_in, alu_in};
      nw = !m_busy && wr_stb;
      nr = !m_busy && rd_stb && !wr_stb;
      if (nw || nr) begin
        m_addr = int'(bus_in) % 1024;
        m_half = bus_in[10];
        if (other_stall) m_flag = 1;
      end
      if (nr) m_rdata = mdl.exists(m_addr) ? mdl[m_addr] : 32'h0;
      m_busy = nw || nr; m_wrp = nw; m_rdp = nr;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (!done) begin
      chk("R3", "stall_o", {15'd0, stall_o}, {15'd0, m_busy});
      chk("R9", "unspec_o", {15'd0, unspec_o}, {15'd0, m_flag});
      chk("R5", "bus_and_o", bus_and_o,
          m_rdp ? (m_half ? m_rdata[31:16] : m_rdata[15:0]) : 16'hFFFF);
    end
  end

  // one cycle of stimulus; returns at the negedge where its effect is visible
  task automatic drv(input logic rd, input logic wr, input logic [15:0] b,
                     input logic [15:0] h, input logic [15:0] a, input logic os);
    #1;
    rd_stb = rd; wr_stb = wr; bus_in = b; hold_in = h; alu_in = a; other_stall = os;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] b, input logic [15:0] h, input logic [15:0] a);
    drv(0, 1, b, 16'h0, 16'h0, 0);
    drv(0, 0, 16'h0, h, a, 0);
  endtask

  task automatic read_chk(input string req, input logic [15:0] b, input logic [15:0] exp);
    drv(1, 0, b, 16'h0, 16'h0, 0);
    chk(req, "read half", bus_and_o, exp);
    drv(0, 0, 16'h0, 16'h0, 16'h0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset stall", {15'd0, stall_o}, 16'd0);
    chk("R10", "reset flag", {15'd0, unspec_o}, 16'd0);
    chk("R10", "reset mask", bus_and_o, 16'hFFFF);
    #1 rst = 0;
    @(negedge clk);

    // R1/R2/R3: two-cycle write
    drv(0, 1, 16'h0005, 16'h0, 16'h0, 0);
    chk("R3", "stall after strobe", {15'd0, stall_o}, 16'd1);
    drv(0, 0, 16'h0, 16'hA5A5, 16'h3C3C, 0);
    chk("R3", "stall released", {15'd0, stall_o}, 16'd0);
    read_chk("R1", 16'h0405, 16'hA5A5);
    read_chk("R2", 16'h0005, 16'h3C3C);
    chk("R5", "idle mask", bus_and_o, 16'hFFFF);
    read_chk("R4", 16'h0405, 16'hA5A5);

    // R6: wrap-around, upper bus bits ignored
    write_word(16'hF9FF, 16'h1234, 16'h5678);
    read_chk("R6", 16'h05FF, 16'h1234);
    read_chk("R6", 16'hB9FF, 16'h5678);

    // R7: strobes in the stall cycle are dropped
    drv(0, 1, 16'h0007, 16'h0, 16'h0, 0);
    drv(1, 1, 16'h0008, 16'h1111, 16'h2222, 0);
    chk("R7", "no new stall", {15'd0, stall_o}, 16'd0);
    chk("R7", "no read data", bus_and_o, 16'hFFFF);
    drv(0, 0, 16'h0, 16'h0, 16'h0, 0);
    read_chk("R7", 16'h0407, 16'h1111);
    write_word(16'h0008, 16'h7777, 16'h8888);
    read_chk("R7", 16'h0008, 16'h8888);

    // R8: simultaneous strobes -> write only
    drv(1, 1, 16'h0409, 16'h0, 16'h0, 0);
    chk("R8", "no read data", bus_and_o, 16'hFFFF);
    chk("R8", "stalled", {15'd0, stall_o}, 16'd1);
    drv(0, 0, 16'h0, 16'hABCD, 16'hEF01, 0);
    read_chk("R8", 16'h0409, 16'hABCD);
    read_chk("R8", 16'h0009, 16'hEF01);

    // R9: overlap with another stall cause
    chk("R9", "flag clear", {15'd0, unspec_o}, 16'd0);
    drv(1, 0, 16'h0005, 16'h0, 16'h0, 1);
    chk("R9", "stall unchanged", {15'd0, stall_o}, 16'd1);
    chk("R9", "flag set", {15'd0, unspec_o}, 16'd1);
    drv(0, 0, 16'h0, 16'h0, 16'h0, 0);
    drv(0, 0, 16'h0, 16'h0, 16'h0, 0);
    chk("R9", "flag sticky", {15'd0, unspec_o}, 16'd1);

    // mixed patterns, model-compared every cycle
    for (int i = 0; i < 8; i++)
      write_word(16'((i * 37 + 100) | (i << 11)), 16'(i * 16'h1111), 16'(~(i * 16'h0F0F)));
    for (int i = 0; i < 8; i++) begin
      drv(1, 0, 16'((i * 37 + 100) | ((i & 1) << 10)), 16'h0, 16'h0, 0);
      drv(0, 0, 16'h0, 16'h0, 16'h0, 0);
    end

    // R10: reset clears the flag
    #1 rst = 1;
    @(negedge clk);
    chk("R10", "flag cleared", {15'd0, unspec_o}, 16'd0);
    chk("R10", "stall cleared", {15'd0, stall_o}, 16'd0);
    #1 rst = 0;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule